// File: doc/BRIEF.md
# Two-Way Translation Buffer with Staged Debug Entry Loading

This block holds a small two-way set-associative translation buffer. Each entry maps a virtual page number to a physical page and carries a domain number, a two-bit permission code, and cacheable and bufferable attributes. Entries are not written directly. Software first loads a tag staging word and a physical/protection staging word through a one-word command port. It then issues a transfer command, which copies both staged words into one way of one set.

A lookup port compares a virtual page number against both ways of the set chosen by its low bits. It returns the physical page number and attributes of a single matching entry. It also reports whether the requested access, given a privileged-mode bit and a write bit, is allowed by that entry's permission code. Lookups are combinational from the stored entries, so an entry committed on one clock edge is visible during the next cycle.

Top module: `tlb_dbg_store`

## Requirements
- R1: `cmd_sel` decodes as follows: 01 loads the tag staging word, 10 loads the physical/protection staging word, 11 requests a transfer, and 00 does nothing. No command takes effect while `cmd_valid` is low.
- R2: The tag word carries these fields. Bit 0 is the valid flag, bit 1 is the target way, and bits [31:10] are the virtual page number. The set index is the low log2(SETS) bits of that page number, so page numbers that differ only above those bits share a set and can be held in opposite ways at the same time.
- R3: The physical/protection word carries these fields. Bit 0 is bufferable, bit 1 is cacheable, bits [3:2] are the permission code, bits [7:4] are the domain number (0 to 15), and bits [31:10] are the physical page number. Bits [9:8] have no effect on any stored field.
- R4: A transfer is accepted only if both staging words have been written since the previous transfer command. Every transfer command, accepted or not, clears both written marks.
- R5: `xfer_reject` reads 1 from the cycle after a rejected transfer until the next transfer command. It reads 0 after an accepted transfer and after reset.
- R6: An accepted transfer writes the staged entry into the addressed way and set, replacing what was there. A lookup in the next cycle returns the new contents.
- R7: `lk_hit` is 1 when exactly one valid way of the indexed set holds the requested page number. When `lk_hit` is 0, the physical page, domain, permission code and attribute outputs all read 0.
- R8: When both ways of the indexed set are valid and match, `lk_multi` is 1 and `lk_hit` is 0.
- R9: `lk_allow` follows the permission code of the hit entry. Code 00 allows nothing. Code 01 allows privileged reads and writes only. Code 10 allows privileged reads and writes and user reads. Code 11 allows every access.
- R10: `lk_allow` is 0 on a miss and on a multiple hit.
- R11: A synchronous reset invalidates every entry, clears both staging words and their written marks, and clears `xfer_reject`.
- R12: Transferring a tag word whose valid flag is 0 removes the entry held in that way and set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe for this cycle |
| cmd_sel | input | 2 | Command selector (R1 encoding) |
| cmd_data | input | 32 | Staging word data |
| lk_vpn | input | 22 | Virtual page number to look up |
| lk_priv | input | 1 | Lookup request is privileged |
| lk_write | input | 1 | Lookup request is a write |
| lk_hit | output | 1 | Exactly one valid way matched |
| lk_multi | output | 1 | Both ways matched |
| lk_pa | output | 22 | Physical page number of the hit entry |
| lk_domain | output | 4 | Domain number of the hit entry |
| lk_ap | output | 2 | Permission code of the hit entry |
| lk_cache | output | 1 | Cacheable attribute of the hit entry |
| lk_buf | output | 1 | Bufferable attribute of the hit entry |
| lk_allow | output | 1 | Requested access is permitted |
| xfer_reject | output | 1 | Last transfer command was refused |

## Verification
The bench builds the block with SETS set to 4. With only two index bits, page numbers chosen a few apart land in the same set. This lets the bench place aliasing pages side by side in opposite ways, provoke a double match, and then remove one copy with a short sequence. It also fills all four sets with one entry per permission code. Every combination of privilege and access type can then be swept against every code within a handful of cycles.

// File: rtl/tlb_dbg_pkg.sv
package tlb_dbg_pkg;

    localparam int VPN_W = 22;
    localparam int PA_W  = 22;
    localparam int DOM_W = 4;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_TAG  = 2'b01,
        CMD_PROT = 2'b10,
        CMD_XFER = 2'b11
    } cmd_e;

    localparam logic [1:0] AP_DENY      = 2'b00;
    localparam logic [1:0] AP_PRIV_ONLY = 2'b01;
    localparam logic [1:0] AP_USER_RO   = 2'b10;
    localparam logic [1:0] AP_ALL       = 2'b11;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  pa;
        logic [DOM_W-1:0] dom;
        logic [1:0]       ap;
        logic             cache;
        logic             buff;
    } tlb_entry_t;

    function automatic logic ap_permits(input logic [1:0] ap,
                                        input logic priv,
                                        input logic wr);
        logic ok;
        unique case (ap)
            AP_DENY:      ok = 1'b0;
            AP_PRIV_ONLY: ok = priv;
            AP_USER_RO:   ok = priv | ~wr;
            default:      ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_stage_regs.sv
module tlb_stage_regs
    import tlb_dbg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_sel,
    input  logic [31:0]      cmd_data,
    output logic             commit_o,
    output logic             commit_way_o,
    output logic [IDX_W-1:0] commit_set_o,
    output tlb_entry_t       commit_entry_o,
    output logic             reject_o
);

    typedef struct packed {
        logic [31:0] tag;
        logic [31:0] prot;
        logic        tag_seen;
        logic        prot_seen;
        logic        reject;
    } stage_t;

    stage_t st_d, st_q;
    logic   xfer_cmd;
    logic   accept;
    logic   unused_stage_bits;

    always_comb begin
        st_d     = st_q;
        xfer_cmd = cmd_valid && (cmd_e'(cmd_sel) == CMD_XFER);
        accept   = xfer_cmd && st_q.tag_seen && st_q.prot_seen;
        if (cmd_valid) begin
            unique case (cmd_e'(cmd_sel))
                CMD_TAG: begin
                    st_d.tag      = cmd_data;
                    st_d.tag_seen = 1'b1;
                end
                CMD_PROT: begin
                    st_d.prot      = cmd_data;
                    st_d.prot_seen = 1'b1;
                end
                CMD_XFER: begin
                    st_d.tag_seen  = 1'b0;
                    st_d.prot_seen = 1'b0;
                    st_d.reject    = ~accept;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        commit_entry_o.valid = st_q.tag[0];
        commit_entry_o.vpn   = st_q.tag[31:10];
        commit_entry_o.pa    = st_q.prot[31:10];
        commit_entry_o.dom   = st_q.prot[7:4];
        commit_entry_o.ap    = st_q.prot[3:2];
        commit_entry_o.cache = st_q.prot[1];
        commit_entry_o.buff  = st_q.prot[0];
    end

    assign commit_o          = accept;
    assign commit_way_o      = st_q.tag[1];
    assign commit_set_o      = st_q.tag[10 +: IDX_W];
    assign reject_o          = st_q.reject;
    assign unused_stage_bits = ^{st_q.tag[9:2], st_q.prot[9:8]};

endmodule

// File: rtl/tlb_entry_ram.sv
module tlb_entry_ram
    import tlb_dbg_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_way,
    input  logic [IDX_W-1:0] wr_set,
    input  tlb_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_set,
    output tlb_entry_t [1:0] rd_entry
);

    localparam int WAYS = 2;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_entry_t bank_d [SETS];
        tlb_entry_t bank_q [SETS];
        logic       sel_way;

        assign sel_way = (wr_way == (w != 0));

        always_comb begin
            bank_d = bank_q;
            if (wr_en && sel_way) begin
                bank_d[wr_set] = wr_entry;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '{default: '0};
            end else begin
                bank_q <= bank_d;
            end
        end

        assign rd_entry[w] = bank_q[rd_set];
    end

endmodule

// File: rtl/tlb_lookup_eval.sv
module tlb_lookup_eval
    import tlb_dbg_pkg::*;
(
    input  tlb_entry_t [1:0] ways,
    input  logic [VPN_W-1:0] vpn,
    input  logic             priv,
    input  logic             wr,
    output logic             hit,
    output logic             multi,
    output tlb_entry_t       found,
    output logic             allow
);

    logic [1:0] match;

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            match[w] = ways[w].valid && (ways[w].vpn == vpn);
        end
        hit   = match[0] ^ match[1];
        multi = match[0] & match[1];
        found = '0;
        if (hit) begin
            found = match[1] ? ways[1] : ways[0];
        end
        allow = hit && ap_permits(found.ap, priv, wr);
    end

endmodule

// File: rtl/tlb_dbg_store.sv
module tlb_dbg_store
    import tlb_dbg_pkg::*;
#(
    parameter int SETS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_sel,
    input  logic [31:0] cmd_data,
    input  logic [21:0] lk_vpn,
    input  logic        lk_priv,
    input  logic        lk_write,
    output logic        lk_hit,
    output logic        lk_multi,
    output logic [21:0] lk_pa,
    output logic [3:0]  lk_domain,
    output logic [1:0]  lk_ap,
    output logic        lk_cache,
    output logic        lk_buf,
    output logic        lk_allow,
    output logic        xfer_reject
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

    logic             commit;
    logic             commit_way;
    logic [IDX_W-1:0] commit_set;
    tlb_entry_t       commit_entry;
    tlb_entry_t [1:0] set_ways;
    tlb_entry_t       found;

    tlb_stage_regs #(.IDX_W(IDX_W)) u_stage (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_sel        (cmd_sel),
        .cmd_data       (cmd_data),
        .commit_o       (commit),
        .commit_way_o   (commit_way),
        .commit_set_o   (commit_set),
        .commit_entry_o (commit_entry),
        .reject_o       (xfer_reject)
    );

    tlb_entry_ram #(.SETS(SETS), .IDX_W(IDX_W)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (commit),
        .wr_way   (commit_way),
        .wr_set   (commit_set),
        .wr_entry (commit_entry),
        .rd_set   (lk_vpn[IDX_W-1:0]),
        .rd_entry (set_ways)
    );

    tlb_lookup_eval u_eval (
        .ways  (set_ways),
        .vpn   (lk_vpn),
        .priv  (lk_priv),
        .wr    (lk_write),
        .hit   (lk_hit),
        .multi (lk_multi),
        .found (found),
        .allow (lk_allow)
    );

    assign lk_pa     = found.pa;
    assign lk_domain = found.dom;
    assign lk_ap     = found.ap;
    assign lk_cache  = found.cache;
    assign lk_buf    = found.buff;

endmodule

// File: rtl/tlb_dbg_store_chk.sv
module tlb_dbg_store_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_sel,
    input logic        lk_hit,
    input logic        lk_multi,
    input logic [21:0] lk_pa,
    input logic [1:0]  lk_ap,
    input logic        lk_allow,
    input logic        xfer_reject
);

    logic prev_xfer_q;
    logic rst_seen_q;
    logic xfer_now;

    assign xfer_now = cmd_valid && (cmd_sel == 2'b11);

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            prev_xfer_q <= 1'b0;
        end else begin
            prev_xfer_q <= xfer_now;
        end
    end

    AST_HIT_MULTI_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_multi)); // R8

    AST_MISS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == '0) && (lk_ap == 2'b00)); // R7

    AST_MISS_NO_ALLOW: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> !lk_allow); // R10

    AST_AP_DENY_ALL: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_ap == 2'b00) |-> !lk_allow); // R9

    AST_AP_OPEN_ALL: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_ap == 2'b11) |-> lk_allow); // R9

    AST_BACK_TO_BACK_REJECT: assert property (@(posedge clk) disable iff (rst)
        (prev_xfer_q && xfer_now) |=> xfer_reject); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rst_seen_q |-> (!xfer_reject && !lk_hit && !lk_multi)); // R11

endmodule

bind tlb_dbg_store tlb_dbg_store_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_sel     (cmd_sel),
    .lk_hit      (lk_hit),
    .lk_multi    (lk_multi),
    .lk_pa       (lk_pa),
    .lk_ap       (lk_ap),
    .lk_allow    (lk_allow),
    .xfer_reject (xfer_reject)
);

// File: tb/tlb_dbg_store_test.sv
module tlb_dbg_store_test;

    localparam int CLK_PERIOD = 10;
    localparam int TB_SETS    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_sel = 2'b00;
    logic [31:0] cmd_data = '0;
    logic [21:0] lk_vpn = '0;
    logic        lk_priv = 1'b0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_multi, lk_cache, lk_buf, lk_allow, xfer_reject;
    logic [21:0] lk_pa;
    logic [3:0]  lk_domain;
    logic [1:0]  lk_ap;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    logic        m_valid [2][TB_SETS];
    logic [21:0] m_vpn   [2][TB_SETS];
    logic [21:0] m_pa    [2][TB_SETS];
    logic [3:0]  m_dom   [2][TB_SETS];
    logic [1:0]  m_ap    [2][TB_SETS];
    logic        m_c     [2][TB_SETS];
    logic        m_b     [2][TB_SETS];
    logic [31:0] m_tag, m_prot;
    bit          m_tseen, m_pseen, m_reject;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_dbg_store #(.SETS(TB_SETS)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .lk_vpn(lk_vpn), .lk_priv(lk_priv),
        .lk_write(lk_write), .lk_hit(lk_hit), .lk_multi(lk_multi),
        .lk_pa(lk_pa), .lk_domain(lk_domain), .lk_ap(lk_ap),
        .lk_cache(lk_cache), .lk_buf(lk_buf), .lk_allow(lk_allow),
        .xfer_reject(xfer_reject)
    );

    function automatic logic [31:0] mk_tag(input logic [21:0] vpn,
                                           input logic way, input logic v);
        return {vpn, 8'h00, way, v};
    endfunction

    function automatic logic [31:0] mk_prot(input logic [21:0] pa,
                                            input logic [3:0] dom,
                                            input logic [1:0] ap,
                                            input logic c, input logic b);
        return {pa, 2'b00, dom, ap, c, b};
    endfunction

    function automatic logic may_access(input logic [1:0] ap,
                                        input logic priv, input logic wr);
        if (ap == 2'd0) return 1'b0;
        if (ap == 2'd3) return 1'b1;
        if (!priv) return (ap == 2'd2) && !wr;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int n = 0;
        int fw = 0;
        int s = int'(lk_vpn) % TB_SETS;
        logic e_hit;
        for (int w = 0; w < 2; w++) begin
            if (m_valid[w][s] && m_vpn[w][s] == lk_vpn) begin
                n++;
                fw = w;
            end
        end
        e_hit = (n == 1);
        chk(req, "hit",    32'(lk_hit),   32'(e_hit));
        chk(req, "multi",  32'(lk_multi), 32'(n == 2));
        chk(req, "pa",     32'(lk_pa),     e_hit ? 32'(m_pa[fw][s])  : 32'd0);
        chk(req, "domain", 32'(lk_domain), e_hit ? 32'(m_dom[fw][s]) : 32'd0);
        chk(req, "ap",     32'(lk_ap),     e_hit ? 32'(m_ap[fw][s])  : 32'd0);
        chk(req, "cache",  32'(lk_cache),  e_hit ? 32'(m_c[fw][s])   : 32'd0);
        chk(req, "buf",    32'(lk_buf),    e_hit ? 32'(m_b[fw][s])   : 32'd0);
        chk(req, "allow",  32'(lk_allow),
            e_hit ? 32'(may_access(m_ap[fw][s], lk_priv, lk_write)) : 32'd0);
        chk(req, "reject", 32'(xfer_reject), 32'(m_reject));
    endtask

    task automatic model_clear();
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < TB_SETS; s++) begin
                m_valid[w][s] = 1'b0;
                m_vpn[w][s] = '0; m_pa[w][s] = '0; m_dom[w][s] = '0;
                m_ap[w][s] = '0;  m_c[w][s] = 1'b0; m_b[w][s] = 1'b0;
            end
        end
        m_tag = '0; m_prot = '0;
        m_tseen = 0; m_pseen = 0; m_reject = 0;
    endtask

    task automatic model_edge();
        if (rst) begin
            model_clear();
        end else if (cmd_valid) begin
            case (cmd_sel)
                2'd1: begin m_tag = cmd_data;  m_tseen = 1; end
                2'd2: begin m_prot = cmd_data; m_pseen = 1; end
                2'd3: begin
                    if (m_tseen && m_pseen) begin
                        int w = int'(m_tag[1]);
                        int s = int'(m_tag[31:10]) % TB_SETS;
                        m_valid[w][s] = m_tag[0];
                        m_vpn[w][s]   = m_tag[31:10];
                        m_pa[w][s]    = m_prot[31:10];
                        m_dom[w][s]   = m_prot[7:4];
                        m_ap[w][s]    = m_prot[3:2];
                        m_c[w][s]     = m_prot[1];
                        m_b[w][s]     = m_prot[0];
                        m_reject      = 0;
                    end else begin
                        m_reject = 1;
                    end
                    m_tseen = 0;
                    m_pseen = 0;
                end
                default: ;
            endcase
        end
    endtask

    // one clock: drive at the falling edge, compare, then advance the model
    task automatic cyc(input logic v, input logic [1:0] sel,
                       input logic [31:0] d, input string req);
        @(negedge clk);
        cmd_valid = v;
        cmd_sel   = sel;
        cmd_data  = d;
        #1;
        compare(req);
        @(posedge clk);
        model_edge();
    endtask

    task automatic look(input logic [21:0] vpn, input logic priv,
                        input logic wr, input string req);
        lk_vpn   = vpn;
        lk_priv  = priv;
        lk_write = wr;
        cyc(1'b0, 2'b00, 32'h0, req);
    endtask

    task automatic load(input logic [31:0] tag, input logic [31:0] prot,
                        input string req);
        cyc(1'b1, 2'b01, tag,  req);
        cyc(1'b1, 2'b10, prot, req);
        cyc(1'b1, 2'b11, '0,   req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (2) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R11: nothing valid after reset
        look(22'h0ABC5, 1'b1, 1'b0, "R11");

        // R4: transfer with empty staging is refused; R5 flag holds
        cyc(1'b1, 2'b11, '0, "R4");
        look(22'h0ABC5, 1'b1, 1'b0, "R5");
        look(22'h0ABC5, 1'b0, 1'b1, "R5");

        // R6: staged entry becomes visible the cycle after transfer
        load(mk_tag(22'h0ABC5, 1'b0, 1'b1),
             mk_prot(22'h3F00F, 4'd9, 2'b11, 1'b1, 1'b0), "R6");
        look(22'h0ABC5, 1'b0, 1'b1, "R6");
        // R7: other page in same set misses
        look(22'h0ABC1, 1'b1, 1'b0, "R7");

        // R1: strobe-low commands have no effect
        cyc(1'b1, 2'b01, mk_tag(22'h00011, 1'b1, 1'b1), "R1");
        cyc(1'b1, 2'b10, mk_prot(22'h12345, 4'd3, 2'b10, 1'b0, 1'b1), "R1");
        cyc(1'b0, 2'b01, mk_tag(22'h00022, 1'b1, 1'b1), "R1");
        cyc(1'b0, 2'b11, '0, "R1");
        look(22'h00011, 1'b1, 1'b0, "R1");
        cyc(1'b1, 2'b11, '0, "R1");
        look(22'h00011, 1'b0, 1'b0, "R1");
        look(22'h00022, 1'b1, 1'b0, "R1");

        // R2: aliasing pages held in both ways of one set
        look(22'h0ABC5, 1'b1, 1'b1, "R2");
        look(22'h00011, 1'b0, 1'b1, "R2");

        // R3: bits 9:8 of the protection word ignored
        load(mk_tag(22'h00006, 1'b1, 1'b1),
             mk_prot(22'h2AAAA, 4'd15, 2'b01, 1'b1, 1'b1) | 32'h300, "R3");
        look(22'h00006, 1'b1, 1'b0, "R3");
        look(22'h00006, 1'b0, 1'b0, "R3");

        // R8: duplicate tag in both ways
        load(mk_tag(22'h0ABC5, 1'b1, 1'b1),
             mk_prot(22'h00777, 4'd1, 2'b11, 1'b0, 1'b0), "R8");
        look(22'h0ABC5, 1'b1, 1'b0, "R8");
        look(22'h0ABC5, 1'b1, 1'b1, "R10");
        look(22'h00011, 1'b1, 1'b0, "R6");

        // R12: invalidate way 1, way 0 copy hits alone again
        load(mk_tag(22'h0ABC5, 1'b1, 1'b0),
             mk_prot(22'h0, 4'd0, 2'b00, 1'b0, 1'b0), "R12");
        look(22'h0ABC5, 1'b1, 1'b0, "R12");

        // R5: partial staging refused, flag persists, then clears
        cyc(1'b1, 2'b01, mk_tag(22'h00100, 1'b0, 1'b1), "R5");
        cyc(1'b1, 2'b11, '0, "R5");
        look(22'h00100, 1'b1, 1'b0, "R5");
        look(22'h00100, 1'b1, 1'b0, "R5");
        cyc(1'b1, 2'b10, mk_prot(22'h00055, 4'd2, 2'b11, 1'b0, 1'b0), "R4");
        cyc(1'b1, 2'b11, '0, "R4");
        look(22'h00100, 1'b1, 1'b0, "R4");
        load(mk_tag(22'h00100, 1'b0, 1'b1),
             mk_prot(22'h00055, 4'd2, 2'b11, 1'b0, 1'b0), "R5");
        look(22'h00100, 1'b1, 1'b0, "R5");

        // R9: every permission code against every request kind
        for (int ap = 0; ap < 4; ap++) begin
            load(mk_tag(22'h00200 + 22'(ap), 1'b0, 1'b1),
                 mk_prot(22'h01000 + 22'(ap), 4'(ap), 2'(ap), 1'b0, 1'b1), "R9");
        end
        for (int ap = 0; ap < 4; ap++) begin
            for (int pw = 0; pw < 4; pw++) begin
                look(22'h00200 + 22'(ap), pw[1], pw[0], "R9");
            end
        end
        // R10: miss never allows
        look(22'h3FFF3, 1'b1, 1'b0, "R10");

        // R11: mid-run reset clears entries and staging
        cyc(1'b1, 2'b01, mk_tag(22'h00300, 1'b0, 1'b1), "R11");
        do_reset();
        look(22'h00200, 1'b1, 1'b0, "R11");
        look(22'h00203, 1'b1, 1'b1, "R11");
        cyc(1'b1, 2'b10, mk_prot(22'h1, 4'd0, 2'b11, 1'b0, 1'b0), "R11");
        cyc(1'b1, 2'b11, '0, "R11");
        look(22'h00300, 1'b1, 1'b0, "R11");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule